// File: doc/BRIEF.md
# Twin-Predicated Vector Element Mover

This block copies data elements from a source region of a register file to a destination region. Two independent masks control the copy. The source mask selects which source elements are read, and the selected elements are taken in packed order, as a compress would take them. The destination mask selects which destination slots receive data, and the data is spread into those slots, as an expand would spread it. Each selected source element is paired with the selected destination slot of the same rank. Slots that are not selected keep their old contents.

The block handles one element per cycle, in ascending index order. It drives a read port and a write port of the register file. The register file read is combinational, so the data read in a cycle is written in that same cycle. When `start_i` is pulsed, the block captures the vector length, both masks and both base addresses. A copy with an all-ones source mask is a plain expand. A copy with an all-ones destination mask is a plain compress.

Top module: `twin_pred_mover`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `rd_en_o` and `wr_en_o` are all low.
- R2: Source element i (bit i of `src_mask_i`) is read from `src_base_i + i` only when its mask bit is set. Selected source elements are read in ascending order of i.
- R3: Destination slot j (bit j of `dst_mask_i`) is written at `dst_base_i + j` only when its mask bit is set. Every other register keeps its value.
- R4: The k-th selected source element is written to the k-th selected destination slot.
- R5: With an all-ones source mask, the copy behaves as a plain expand: source elements 0, 1, 2, ... fill the selected destination slots in order.
- R6: With an all-ones destination mask, the copy behaves as a plain compress: the selected source elements land in slots 0, 1, 2, ... in order.
- R7: A captured start raises `busy_o` on the next cycle. The block performs min(selected sources, selected destinations) transfers on consecutive cycles. `done_o` is then high for exactly one cycle, which is the last busy cycle, and no transfer occurs in that cycle.
- R8: At most one transfer occurs per cycle. `wr_en_o` is high only in a cycle where `rd_en_o` is high. In that cycle, `wr_data_o` equals `rd_data_i`.
- R9: A `start_i` pulse while `busy_o` is high is ignored. The running copy keeps the masks, length and bases it captured at its own start.
- R10: A vector length of zero, an all-zeros source mask, or an all-zeros destination mask gives `done_o` on the first busy cycle and no write.
- R11: Mask bits at index `vl_i` or above are ignored on both sides. No element index at or above the captured length is read or written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request; sampled only when idle |
| vl_i | input | CNT_W | Vector length (element count) |
| src_mask_i | input | VLEN_MAX | Source predicate mask |
| dst_mask_i | input | VLEN_MAX | Destination predicate mask |
| src_base_i | input | AW | Register address of source element 0 |
| dst_base_i | input | AW | Register address of destination slot 0 |
| busy_o | output | 1 | Copy in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rd_en_o | output | 1 | Register file read enable |
| rd_addr_o | output | AW | Register file read address |
| rd_data_i | input | DATA_W | Register file read data (same cycle) |
| wr_en_o | output | 1 | Register file write enable |
| wr_addr_o | output | AW | Register file write address |
| wr_data_o | output | DATA_W | Register file write data |

## Verification
The bench builds the block with its default parameters: `VLEN_MAX` = 8, `DATA_W` = 16 and `AW` = 5. With these values the source region at 0 and the destination region at 16 both fit in a 32-entry model register file. Full-length copies, all-ones masks and every length from 0 to 8 are therefore in reach. The small mask width lets directed patterns reach each termination case: sources running out first, destinations running out first, and mask bits placed above the length. Randomized masks and lengths then cover the uneven pairings between source and destination ranks.

// File: rtl/twin_pred_pkg.sv
package twin_pred_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } mover_state_e;
endpackage

// File: rtl/pred_walker.sv
module pred_walker #(
  parameter int unsigned N     = 8,
  parameter int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [N-1:0]     mask_i,
  input  logic [N-1:0]     lim_i,
  input  logic             adv_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  // remaining selected positions; lowest set bit is the current index
  logic [N-1:0] rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rem_q <= '0;
    else if (load_i) rem_q <= mask_i & lim_i;
    else if (adv_i)  rem_q <= rem_q & (rem_q - 1'b1);
  end

  assign found_o = |rem_q;

  always_comb begin
    idx_o = '0;
    for (int i = int'(N) - 1; i >= 0; i--) begin
      if (rem_q[i]) idx_o = IDX_W'(i);
    end
  end

  // R8: only advance on a live element
  a_r8_adv_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |-> found_o);

  // R2: each advance consumes exactly one selected element
  a_r2_walk_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i) |=> ($countones(rem_q) == $countones($past(rem_q)) - 1));

  // R2: indices strictly ascend
  a_r2_ascending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i) |=> (!found_o || (idx_o > $past(idx_o))));
endmodule

// File: rtl/tpm_ctrl.sv
module tpm_ctrl
  import twin_pred_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic src_found_i,
  input  logic dst_found_i,
  output logic load_o,
  output logic xfer_o,
  output logic busy_o,
  output logic done_o
);
  mover_state_e state_q, state_d;

  always_comb begin
    load_o  = (state_q == ST_IDLE) && start_i;
    xfer_o  = (state_q == ST_RUN) && src_found_i && dst_found_i;
    done_o  = (state_q == ST_RUN) && !(src_found_i && dst_found_i);
    busy_o  = (state_q == ST_RUN);
    state_d = state_q;
    if (load_o)      state_d = ST_RUN;
    else if (done_o) state_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  a_r7_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r7_done_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);

  a_r7_start_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> busy_o);

  a_r9_no_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !load_o);

  a_r8_xfer_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(xfer_o && done_o));
endmodule

// File: rtl/twin_pred_mover.sv
module twin_pred_mover #(
  parameter int unsigned VLEN_MAX = 8,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned AW       = 5,
  localparam int unsigned IDX_W   = (VLEN_MAX > 1) ? $clog2(VLEN_MAX) : 1,
  localparam int unsigned CNT_W   = $clog2(VLEN_MAX + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [CNT_W-1:0]    vl_i,
  input  logic [VLEN_MAX-1:0] src_mask_i,
  input  logic [VLEN_MAX-1:0] dst_mask_i,
  input  logic [AW-1:0]       src_base_i,
  input  logic [AW-1:0]       dst_base_i,
  output logic                busy_o,
  output logic                done_o,
  output logic                rd_en_o,
  output logic [AW-1:0]       rd_addr_o,
  input  logic [DATA_W-1:0]   rd_data_i,
  output logic                wr_en_o,
  output logic [AW-1:0]       wr_addr_o,
  output logic [DATA_W-1:0]   wr_data_o
);
  logic                load, xfer;
  logic                src_found, dst_found;
  logic [IDX_W-1:0]    src_idx, dst_idx;
  logic [VLEN_MAX-1:0] len_lim;
  logic [CNT_W-1:0]    vl_q;
  logic [AW-1:0]       src_base_q, dst_base_q;

  for (genvar g = 0; g < VLEN_MAX; g++) begin : g_lim
    assign len_lim[g] = (CNT_W'(g) < vl_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vl_q       <= '0;
      src_base_q <= '0;
      dst_base_q <= '0;
    end else if (load) begin
      vl_q       <= vl_i;
      src_base_q <= src_base_i;
      dst_base_q <= dst_base_i;
    end
  end

  tpm_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .src_found_i(src_found),
    .dst_found_i(dst_found),
    .load_o     (load),
    .xfer_o     (xfer),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );

  pred_walker #(.N(VLEN_MAX), .IDX_W(IDX_W)) u_src_walk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .mask_i (src_mask_i),
    .lim_i  (len_lim),
    .adv_i  (xfer),
    .found_o(src_found),
    .idx_o  (src_idx)
  );

  pred_walker #(.N(VLEN_MAX), .IDX_W(IDX_W)) u_dst_walk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .mask_i (dst_mask_i),
    .lim_i  (len_lim),
    .adv_i  (xfer),
    .found_o(dst_found),
    .idx_o  (dst_idx)
  );

  assign rd_en_o   = xfer;
  assign rd_addr_o = src_base_q + AW'(src_idx);
  assign wr_en_o   = xfer;
  assign wr_addr_o = dst_base_q + AW'(dst_idx);
  assign wr_data_o = rd_data_i;

  a_r8_rw_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> rd_en_o);

  a_r8_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!wr_en_o && !rd_en_o));

  a_r11_src_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |-> (CNT_W'(rd_addr_o - src_base_q) < vl_q));

  a_r11_dst_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (CNT_W'(wr_addr_o - dst_base_q) < vl_q));
endmodule

// File: tb/twin_pred_mover_tb.sv
module twin_pred_mover_tb_top;
  localparam int unsigned VLEN_MAX = 8;
  localparam int unsigned DATA_W   = 16;
  localparam int unsigned AW       = 5;
  localparam int unsigned CNT_W    = $clog2(VLEN_MAX + 1);
  localparam int unsigned NREG     = 1 << AW;
  localparam logic [AW-1:0] SRC_B  = 5'd0;
  localparam logic [AW-1:0] DST_B  = 5'd16;

  typedef struct packed {
    logic [AW-1:0]     ra;
    logic [AW-1:0]     wa;
    logic [DATA_W-1:0] wd;
  } exp_t;

  logic                clk = 1'b0;
  logic                rst_ni = 1'b0;
  logic                start_i = 1'b0;
  logic [CNT_W-1:0]    vl_i = '0;
  logic [VLEN_MAX-1:0] src_mask_i = '0, dst_mask_i = '0;
  logic                busy_o, done_o, rd_en_o, wr_en_o;
  logic [AW-1:0]       rd_addr_o, wr_addr_o;
  logic [DATA_W-1:0]   rd_data_i, wr_data_o;

  logic [DATA_W-1:0] regs [NREG];
  logic [DATA_W-1:0] img  [NREG];
  logic              fill_en = 1'b0;
  logic [7:0]        fill_seed = '0;
  exp_t              q[$];
  int                n_vec = 0, n_err = 0, cyc_all = 0;

  always #10 clk = ~clk;

  twin_pred_mover #(.VLEN_MAX(VLEN_MAX), .DATA_W(DATA_W), .AW(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .vl_i(vl_i),
    .src_mask_i(src_mask_i), .dst_mask_i(dst_mask_i),
    .src_base_i(SRC_B), .dst_base_i(DST_B),
    .busy_o(busy_o), .done_o(done_o),
    .rd_en_o(rd_en_o), .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i),
    .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o)
  );

  function automatic logic [DATA_W-1:0] pat(logic [7:0] s, int a);
    return {s, 8'(a)};
  endfunction

  assign rd_data_i = regs[rd_addr_o];

  always @(posedge clk) begin
    if (fill_en) begin
      for (int a = 0; a < NREG; a++) regs[a] <= pat(fill_seed, a);
    end else if (wr_en_o) begin
      regs[wr_addr_o] <= wr_data_o;
    end
  end

  task automatic chk(bit ok, string tag, int act, int expv);
    n_vec++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // monitor: pop expected transfers as the design issues them
  always @(negedge clk) begin
    if (rst_ni && wr_en_o) begin
      if (q.size() == 0) begin
        chk(1'b0, "R3 unexpected write", int'(wr_addr_o), -1);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(rd_en_o && rd_addr_o == e.ra, "R2 read addr", int'(rd_addr_o), int'(e.ra));
        chk(wr_addr_o == e.wa, "R4 write addr", int'(wr_addr_o), int'(e.wa));
        chk(wr_data_o == e.wd, "R4/R8 write data", int'(wr_data_o), int'(e.wd));
      end
    end
  end

  always @(posedge clk) begin
    cyc_all++;
    if (cyc_all > 100000) begin
      n_err++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc_all);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  // driver: compute expected transfers, launch, and check timing and image
  task automatic run(int vl, logic [VLEN_MAX-1:0] sm, logic [VLEN_MAX-1:0] dm,
                     logic [7:0] seed, string tag, bit poke_busy);
    int si[$], di[$];
    int nexp, cyc;
    @(negedge clk);
    fill_seed = seed;
    fill_en   = 1'b1;
    @(negedge clk);
    fill_en   = 1'b0;
    for (int a = 0; a < NREG; a++) img[a] = pat(seed, a);
    for (int i = 0; i < vl; i++) begin
      if (sm[i]) si.push_back(i);
      if (dm[i]) di.push_back(i);
    end
    nexp = (si.size() < di.size()) ? si.size() : di.size();
    for (int k = 0; k < nexp; k++) begin
      exp_t e;
      e.ra = SRC_B + AW'(si[k]);
      e.wa = DST_B + AW'(di[k]);
      e.wd = pat(seed, int'(e.ra));
      img[e.wa] = e.wd;
      q.push_back(e);
    end
    vl_i = CNT_W'(vl); src_mask_i = sm; dst_mask_i = dm;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    cyc = 1;
    chk(busy_o, {tag, " R7 busy after start"}, int'(busy_o), 1);
    while (!done_o && cyc < 50) begin
      if (poke_busy && cyc == 1) begin
        start_i = 1'b1; src_mask_i = ~sm; dst_mask_i = ~dm; vl_i = CNT_W'(VLEN_MAX);
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    start_i = 1'b0;
    chk(cyc == nexp + 1, {tag, " R7 done cycle"}, cyc, nexp + 1);
    chk(q.size() == 0, {tag, " R4 transfers missing"}, q.size(), 0);
    @(negedge clk);
    chk(!busy_o && !done_o, {tag, " R7 done one cycle"}, int'({busy_o, done_o}), 0);
    begin
      int bad;
      bad = -1;
      for (int a = 0; a < NREG; a++) if (regs[a] != img[a]) bad = a;
      chk(bad < 0, {tag, " R3 register image"}, bad, -1);
    end
    q.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !rd_en_o && !wr_en_o, "R1 reset outputs",
        int'({busy_o, done_o, rd_en_o, wr_en_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!busy_o && !wr_en_o, "R1 idle after reset", int'({busy_o, wr_en_o}), 0);

    run(8, 8'hFF, 8'hFF, 8'h11, "R4 full copy", 1'b0);
    run(8, 8'hFF, 8'hA5, 8'h22, "R5 expand", 1'b0);
    run(6, 8'hFF, 8'h2C, 8'h23, "R5 expand short", 1'b0);
    run(8, 8'h5A, 8'hFF, 8'h33, "R6 compress", 1'b0);
    run(7, 8'hC3, 8'hFF, 8'h34, "R6 compress short", 1'b0);
    run(8, 8'h0F, 8'hF0, 8'h44, "R2 disjoint", 1'b0);
    run(8, 8'h81, 8'h7E, 8'h45, "R7 src runs out", 1'b0);
    run(8, 8'hF7, 8'h12, 8'h46, "R7 dst runs out", 1'b0);
    run(5, 8'hF3, 8'hE4, 8'h55, "R11 bits above vl", 1'b0);
    run(1, 8'hFE, 8'hFF, 8'h56, "R11 vl one", 1'b0);
    run(0, 8'hFF, 8'hFF, 8'h66, "R10 vl zero", 1'b0);
    run(8, 8'h00, 8'hFF, 8'h67, "R10 src zero", 1'b0);
    run(8, 8'hFF, 8'h00, 8'h68, "R10 dst zero", 1'b0);
    run(8, 8'h36, 8'hD9, 8'h77, "R9 start while busy", 1'b1);
    for (int t = 0; t < 24; t++) begin
      run(int'($urandom_range(0, VLEN_MAX)), 8'($urandom), 8'($urandom),
          8'(t + 8'h80), "R4 random", 1'b0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule